// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block tracks the shared program counter and the 32-lane active mask of one warp as it meets control flow. Each accepted control operation arrives on a single-beat input stream with the operation kind, a per-lane taken mask, a branch target and a fall-through address. The block then updates the warp's PC and active mask. An explicit stack of reconvergence entries lets a divergent branch run its taken lanes first and its remaining lanes afterwards. The two groups always run one after the other and never together. Once both groups are done, the warp resumes at the recorded reconvergence address with the mask it had before the split.

A branch on which every active lane agrees is uniform. It moves to the chosen side only, with no stack entry. Lanes outside the active mask stay idle until a pop restores them. The stack holds a fixed number of entries. A push onto a full stack is dropped and raises a sticky overflow flag.

The input stream never applies back-pressure: `br_ready` is held high, so a beat is taken on every cycle that `br_valid` is high. Cycles with `br_valid` low leave all state untouched.

Top module: `simt_reconv_unit`

## Requirements
- R1: After reset, `pc` equals the RESET_PC parameter (default 0), `active_mask` is all ones, `stack_overflow` is 0 and the stack is empty.
- R2: Operation code 2'b00 (sequential) sets `pc` to `br_fallthru` on the next cycle and leaves the mask unchanged.
- R3: Operation code 2'b01 (set reconvergence) pushes an entry holding `br_target` and the current active mask, and sets `pc` to `br_fallthru`.
- R4: Operation code 2'b10 (branch) with `br_taken & active_mask` equal to zero sets `pc` to `br_fallthru`, keeps the mask and pushes nothing.
- R5: A branch with `br_taken & active_mask` equal to the active mask (uniform taken) sets `pc` to `br_target`, keeps the mask and pushes nothing.
- R6: A branch whose taken lanes are a proper non-empty subset of the active lanes sets `pc` to `br_target` and the mask to `br_taken & active_mask`. It also pushes an entry holding `br_fallthru` and `active_mask & ~br_taken`.
- R7: Operation code 2'b11 (sync) on a non-empty stack removes the newest entry and loads `pc` and `active_mask` from it. After a split, the first sync therefore starts the not-taken lanes, and the second returns to the reconvergence address with the mask from before the split.
- R8: A sync on an empty stack sets `pc` to `br_fallthru` and leaves the mask unchanged.
- R9: A push while the stack holds DEPTH (default 8) entries is dropped and sets `stack_overflow`. The flag stays set until reset. PC and mask still update as the operation otherwise specifies.
- R10: `br_ready` is always 1, and a cycle with `br_valid` low changes neither `pc`, `active_mask` nor the stack.
- R11: Every operation other than a sync leaves the new active mask a subset of the previous one. Masked-off lanes are re-enabled only by a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Control operation beat present |
| br_ready | output | 1 | Always 1; the block accepts every beat |
| br_op | input | 2 | 00 sequential, 01 set reconvergence, 10 branch, 11 sync |
| br_taken | input | LANES | Lanes whose condition selects the target |
| br_target | input | PCW | Branch target or reconvergence address |
| br_fallthru | input | PCW | Address of the next sequential instruction |
| pc | output | PCW | Current warp program counter |
| active_mask | output | LANES | Lanes currently executing |
| stack_overflow | output | 1 | Sticky: a push hit a full stack |

## Verification
Every result is registered once, so `pc`, `active_mask` and `stack_overflow` reflect an accepted beat exactly one clock edge after it. A stacked entry becomes visible through a later sync, on the edge after that sync. The bench drives each beat, waits for the rising edge and advances its own queue-based model. At the following falling edge it compares all outputs against the model, so each comparison lands on the first cycle at which the new value is due. Idle cycles are compared the same way to confirm that nothing moved.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'b00,
    OP_SSY  = 2'b01,
    OP_BRA  = 2'b10,
    OP_SYNC = 2'b11
  } ctl_op_e;
endpackage

// File: rtl/rcv_branch_eval.sv
module rcv_branch_eval #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] eff,
  output logic             none_taken,
  output logic             all_taken,
  output logic             split
);
  always_comb begin
    eff        = taken & active;
    none_taken = (eff == '0);
    all_taken  = (eff == active);
    split      = !none_taken && !all_taken;
  end
endmodule

// File: rtl/rcv_stack.sv
module rcv_stack #(
  parameter int PCW   = 32,
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [PCW-1:0]   push_pc,
  input  logic [LANES-1:0] push_mask,
  output logic [PCW-1:0]   top_pc,
  output logic [LANES-1:0] top_mask,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PCW-1:0]   slot_pc   [DEPTH];
  logic [LANES-1:0] slot_mask [DEPTH];
  logic [LW-1:0]    level;
  logic [IW-1:0]    top_idx;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign top_idx = empty ? '0 : IW'(level - LW'(1));
  assign top_pc   = slot_pc[top_idx];
  assign top_mask = slot_mask[top_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_pc[i]   <= '0;
        slot_mask[i] <= '0;
      end else if (push && !full && level == LW'(i)) begin
        slot_pc[i]   <= push_pc;
        slot_mask[i] <= push_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push && !full)       level <= level + LW'(1);
      else if (pop && !empty)  level <= level - LW'(1);
      if (push && full)        overflow <= 1'b1;
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (full && overflow)); // R9
endmodule

// File: rtl/simt_reconv_unit.sv
module simt_reconv_unit #(
  parameter int          LANES    = 32,
  parameter int          PCW      = 32,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  output logic             br_ready,
  input  logic [1:0]       br_op,
  input  logic [LANES-1:0] br_taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  output logic [PCW-1:0]   pc,
  output logic [LANES-1:0] active_mask,
  output logic             stack_overflow
);
  import simt_pkg::*;

  ctl_op_e          op;
  logic [LANES-1:0] eff;
  logic             none_taken, all_taken, split;
  logic             push, pop, empty, full;
  logic [PCW-1:0]   push_pc, top_pc, pc_n;
  logic [LANES-1:0] push_mask, top_mask, mask_n;

  assign br_ready = 1'b1;
  assign op       = ctl_op_e'(br_op);

  rcv_branch_eval #(.LANES(LANES)) u_eval (
    .active(active_mask), .taken(br_taken), .eff(eff),
    .none_taken(none_taken), .all_taken(all_taken), .split(split)
  );

  rcv_stack #(.PCW(PCW), .LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_pc(push_pc), .push_mask(push_mask),
    .top_pc(top_pc), .top_mask(top_mask),
    .empty(empty), .full(full), .overflow(stack_overflow)
  );

  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    push_pc   = br_fallthru;
    push_mask = active_mask;
    pc_n      = pc;
    mask_n    = active_mask;
    if (br_valid) begin
      unique case (op)
        OP_SEQ: pc_n = br_fallthru;
        OP_SSY: begin
          push    = 1'b1;
          push_pc = br_target;
          pc_n    = br_fallthru;
        end
        OP_BRA: begin
          if (none_taken) begin
            pc_n = br_fallthru;
          end else if (all_taken) begin
            pc_n = br_target;
          end else begin
            push      = 1'b1;
            push_pc   = br_fallthru;
            push_mask = active_mask & ~br_taken;
            mask_n    = eff;
            pc_n      = br_target;
          end
        end
        OP_SYNC: begin
          if (!empty) begin
            pop    = 1'b1;
            pc_n   = top_pc;
            mask_n = top_mask;
          end else begin
            pc_n = br_fallthru;
          end
        end
        default: pc_n = pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= RESET_PC[PCW-1:0];
      active_mask <= '1;
    end else begin
      pc          <= pc_n;
      active_mask <= mask_n;
    end
  end

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && op != OP_SYNC) |=> ((active_mask & ~$past(active_mask)) == '0)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> ($stable(pc) && $stable(active_mask))); // R10
  AST_UNIFORM_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && op == OP_BRA && all_taken && !none_taken) |=>
      (pc == $past(br_target) && $stable(active_mask))); // R5
  AST_SPLIT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && op == OP_BRA && split) |=>
      (active_mask == ($past(br_taken) & $past(active_mask)))); // R6
  AST_EMPTY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && op == OP_SYNC && empty) |=>
      (pc == $past(br_fallthru) && $stable(active_mask))); // R8
endmodule

// File: tb/tb_simt_reconv_unit.sv
module tb_simt_reconv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        br_valid = 0;
  logic        br_ready;
  logic [1:0]  br_op = 0;
  logic [31:0] br_taken = 0, br_target = 0, br_fallthru = 0;
  logic [31:0] pc, active_mask;
  logic        stack_overflow;

  int checks = 0, errors = 0;

  logic [31:0] m_pc, m_mask;
  logic        m_ovf;
  logic [31:0] q_pc[$];
  logic [31:0] q_mask[$];

  simt_reconv_unit dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_op(br_op), .br_taken(br_taken), .br_target(br_target),
    .br_fallthru(br_fallthru), .pc(pc), .active_mask(active_mask),
    .stack_overflow(stack_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag);
    checks++;
    if (pc !== m_pc || active_mask !== m_mask || stack_overflow !== m_ovf || br_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%h ovf=%b rdy=%b expected pc=%h mask=%h ovf=%b rdy=1",
               tag, pc, active_mask, stack_overflow, br_ready, m_pc, m_mask, m_ovf);
    end
  endtask

  task automatic mpush(logic [31:0] p, logic [31:0] m);
    if (q_pc.size() == DEPTH) m_ovf = 1'b1;
    else begin q_pc.push_back(p); q_mask.push_back(m); end
  endtask

  task automatic step(logic v, logic [1:0] op, logic [31:0] tk,
                      logic [31:0] tg, logic [31:0] fl, string tag);
    logic [31:0] eff;
    br_valid = v; br_op = op; br_taken = tk; br_target = tg; br_fallthru = fl;
    @(posedge clk);
    if (v) begin
      case (op)
        2'b00: m_pc = fl;
        2'b01: begin mpush(tg, m_mask); m_pc = fl; end
        2'b10: begin
          eff = tk & m_mask;
          if (eff == 0) m_pc = fl;
          else if (eff == m_mask) m_pc = tg;
          else begin mpush(fl, m_mask & ~tk); m_mask = eff; m_pc = tg; end
        end
        default: begin
          if (q_pc.size() > 0) begin m_pc = q_pc.pop_back(); m_mask = q_mask.pop_back(); end
          else m_pc = fl;
        end
      endcase
    end
    @(negedge clk);
    br_valid = 0;
    chk(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_pc = 0; m_mask = '1; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1");
    step(1, 2'b00, 0, 32'h99, 32'h4, "R2");
    step(0, 2'b10, 32'h5, 32'h77, 32'h55, "R10");
    step(0, 2'b11, 0, 0, 32'h66, "R10");
    step(1, 2'b01, 0, 32'h100, 32'h8, "R3");
    step(1, 2'b10, 32'h0000FFFF, 32'h40, 32'hC, "R6");
    step(1, 2'b01, 0, 32'h80, 32'h44, "R3");
    step(1, 2'b10, 32'h000000FF, 32'h48, 32'h60, "R6");
    step(1, 2'b10, 32'hFFFFFFFF, 32'h4C, 32'h4A, "R5");
    step(1, 2'b10, 32'hFFFFFF00, 32'h90, 32'h50, "R4");
    step(1, 2'b00, 0, 0, 32'h54, "R11");
    step(1, 2'b11, 0, 0, 32'h58, "R7");
    step(1, 2'b11, 0, 0, 32'h64, "R7");
    step(1, 2'b10, 32'h0, 32'h200, 32'h84, "R4");
    step(1, 2'b11, 0, 0, 32'h88, "R7");
    step(1, 2'b11, 0, 0, 32'h10, "R7");
    step(1, 2'b11, 0, 0, 32'h104, "R8");
    for (int i = 0; i < DEPTH + 1; i++)
      step(1, 2'b01, 0, 32'h1000 + i, 32'h200 + i, "R9");
    step(1, 2'b10, 32'h0000000F, 32'h300, 32'h304, "R9");
    step(1, 2'b00, 0, 0, 32'h308, "R9");
    for (int i = 0; i < DEPTH + 1; i++)
      step(1, 2'b11, 0, 0, 32'h400 + i, "R7");
    step(0, 2'b00, 0, 0, 32'h999, "R10");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    m_pc = 0; m_mask = '1; m_ovf = 0; q_pc.delete(); q_mask.delete();
    chk("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule